// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path. It watches an incoming frame as a stream of 8-bit bytes and reads the first six bytes as the destination address. It also takes the frame's declared total length with the start byte. From these it decides whether the frame should be kept or thrown away, and it reports what kind of match made that decision.

Software programs the comparison values, and the block sees them as plain input words:
- a station address,
- a multicast address and a multicast mask,
- a filter-control word.

Each address is 48 bits wide and is split across a low word and a high word.

The decision is a one-cycle pulse that carries an accept flag and a 3-bit match code. The pulse appears a fixed time after the byte that settles the outcome. That byte is the sixth address byte for a normal frame, the last byte of a frame that is too short, or the start byte of a frame that is declared too long. Bytes that arrive after that point are passed over until the frame ends.

The controller is a four-state machine:
- **IDLE** waits for a byte flagged as start of frame.
- **GATHER** collects address bytes.
- **DECIDE** lasts exactly one cycle, and during it the decision is registered.
- **SKIP** discards the rest of the frame.

The transitions are:
- IDLE→GATHER: a start byte arrives and it is neither the last byte nor declared oversized.
- IDLE→DECIDE: the start byte is the last byte, or it is declared oversized.
- GATHER→DECIDE: the sixth byte arrives, or an end-of-frame byte arrives.
- DECIDE→IDLE: the frame has already ended, or it ends during this cycle.
- DECIDE→SKIP: the frame has not ended.
- SKIP→IDLE: an end-of-frame byte arrives.

A new start byte must not be presented while the machine is in DECIDE. After a frame whose end coincides with the decision, the sender leaves at least one idle cycle before the next frame.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is held, and in every cycle without a decision pulse, `dec_valid`, `dec_accept` and `dec_kind` are all 0.
- R2: A frame whose declared length, sampled with its start byte, exceeds MAX_FRAME (default 1518) is dropped with code 0. This holds even for a broadcast destination. A declared length equal to MAX_FRAME is filtered normally.
- R3: A frame that ends before its sixth byte is dropped with code 0. This includes a frame of a single byte.
- R4: If neither R2 nor R3 applies, a destination of all ones is accepted with code 1 (broadcast). The filter-control word does not affect this.
- R5: If bit 5 of `filt_ctl` is 0, every non-broadcast frame that R2 and R3 do not drop is accepted with code 2 (promiscuous). The other bits of `filt_ctl` have no effect.
- R6: When bit 5 is 1 and the 48-bit multicast address is not all ones, the block ANDs the destination with the 48-bit multicast mask. If the result equals the multicast address, the frame is accepted with code 3. When the multicast address is all ones, this comparison is skipped.
- R7: Otherwise, a destination equal to the 48-bit station address is accepted with code 4 (unicast). Every other frame is dropped with code 0.
- R8: Each 48-bit value is {high word bits 15:0, low word}. The first received byte sits in bits 7:0 of the low word, and the fifth byte sits in bits 7:0 of the high word. Bits 31:16 of every high word are ignored.
- R9: `dec_valid` is high for the single cycle that follows the second rising edge after the deciding byte is presented. In other words, the decision is registered one edge after the edge that samples the deciding byte.
- R10: Each frame produces exactly one decision, however long the frame is. Bytes marked valid while the block is idle and not marked as start of frame produce no decision.
- R11: During a decision pulse, `dec_accept` is 1 exactly when `dec_kind` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | This byte starts a frame |
| in_last | input | 1 | This byte ends the frame |
| in_len | input | 16 | Declared frame length, sampled with the start byte |
| stn_lo | input | 32 | Station address, bytes 0 to 3 |
| stn_hi | input | 32 | Station address, bytes 4 and 5 in bits 15:0 |
| mca_lo | input | 32 | Multicast address, bytes 0 to 3 |
| mca_hi | input | 32 | Multicast address, bytes 4 and 5 in bits 15:0 |
| mcm_lo | input | 32 | Multicast mask, bytes 0 to 3 |
| mcm_hi | input | 32 | Multicast mask, bytes 4 and 5 in bits 15:0 |
| filt_ctl | input | 32 | Filter control; bit 5 enables address filtering |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame kept (1) or dropped (0) |
| dec_kind | output | 3 | 0 none, 1 broadcast, 2 promiscuous, 3 multicast, 4 unicast |

## Verification
Each type of internal fault shows up at the ports in a specific way:
- A byte counter that is off by one either moves the decision pulse one cycle away from its expected edge, or places an address byte in the wrong lane, which turns a unicast or multicast hit into code 0.
- A controller stuck outside IDLE swallows the next frame, so that frame's decision pulse never appears.
- A stale length flag or end-of-frame flag mislabels only the next frame, as a drop or as a second pulse.

For these reasons every decision is compared for code, accept flag and the exact edge on which it arrives. In addition, any pulse that no frame predicted counts as a failure.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        KIND_NONE    = 3'd0,
        KIND_BCAST   = 3'd1,
        KIND_PROMISC = 3'd2,
        KIND_MCAST   = 3'd3,
        KIND_UCAST   = 3'd4
    } match_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DECIDE = 2'd2,
        ST_SKIP   = 2'd3
    } fsm_state_e;

endpackage

// File: rtl/rxf_addr_shift.sv
module rxf_addr_shift #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 6,
    parameter int CNT_W  = $clog2(NBYTES + 1),
    localparam int ADDR_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NBYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if (load_first) begin
            byte_cnt <= CNT_W'(1);
        end else if (take && (byte_cnt < FULL_CNT)) begin
            byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end

    // one register per address byte; lane i holds the i-th received byte
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (load_first) begin
                lane_q <= (i == 0) ? din : '0;
            end else if (take && (byte_cnt == CNT_W'(i))) begin
                lane_q <= din;
            end
        end
        assign addr[i*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int REG_W       = 32,
    parameter int CTL_W       = 32,
    parameter int FILT_EN_BIT = 5,
    localparam int HI_W       = ADDR_W - REG_W
) (
    input  logic [ADDR_W-1:0] dest,
    input  logic              too_long,
    input  logic              too_short,
    input  logic [REG_W-1:0]  stn_lo,
    input  logic [REG_W-1:0]  stn_hi,
    input  logic [REG_W-1:0]  mca_lo,
    input  logic [REG_W-1:0]  mca_hi,
    input  logic [REG_W-1:0]  mcm_lo,
    input  logic [REG_W-1:0]  mcm_hi,
    input  logic [CTL_W-1:0]  filt_ctl,
    output match_kind_e       kind
);

    logic [ADDR_W-1:0] stn_addr;
    logic [ADDR_W-1:0] mc_addr;
    logic [ADDR_W-1:0] mc_mask;
    logic              mc_armed;
    logic              unused_upper;

    assign stn_addr = {stn_hi[HI_W-1:0], stn_lo};
    assign mc_addr  = {mca_hi[HI_W-1:0], mca_lo};
    assign mc_mask  = {mcm_hi[HI_W-1:0], mcm_lo};
    assign mc_armed = ~(&mc_addr);

    assign unused_upper = ^{stn_hi[REG_W-1:HI_W], mca_hi[REG_W-1:HI_W],
                            mcm_hi[REG_W-1:HI_W], filt_ctl};

    // priority: length drops, broadcast, filter off, multicast, station
    always_comb begin
        kind = KIND_NONE;
        if (too_long || too_short) begin
            kind = KIND_NONE;
        end else if (&dest) begin
            kind = KIND_BCAST;
        end else if (!filt_ctl[FILT_EN_BIT]) begin
            kind = KIND_PROMISC;
        end else if (mc_armed && ((dest & mc_mask) == mc_addr)) begin
            kind = KIND_MCAST;
        end else if (dest == stn_addr) begin
            kind = KIND_UCAST;
        end
    end

endmodule

// File: rtl/rxf_ctrl_fsm.sv
module rxf_ctrl_fsm
    import rxf_pkg::*;
#(
    parameter int NBYTES    = 6,
    parameter int CNT_W     = $clog2(NBYTES + 1),
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [LEN_W-1:0] in_len,
    input  logic [CNT_W-1:0] byte_cnt,
    input  match_kind_e      kind_in,
    output logic             load_first,
    output logic             take,
    output logic             eval,
    output logic             too_long,
    output logic             too_short,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic [2:0]       dec_kind
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);
    localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_FRAME);

    fsm_state_e state_q, state_d;
    logic       ended_q;
    logic       len_big;

    assign len_big    = in_len > MAX_LEN;
    assign load_first = (state_q == ST_IDLE) && in_valid && in_first;
    assign take       = (state_q == ST_GATHER) && in_valid;
    assign eval       = (state_q == ST_DECIDE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_first) begin
                    state_d = (len_big || in_last) ? ST_DECIDE : ST_GATHER;
                end
            end
            ST_GATHER: begin
                if (in_valid && ((byte_cnt == LAST_IDX) || in_last)) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                state_d = (ended_q || (in_valid && in_last)) ? ST_IDLE : ST_SKIP;
            end
            ST_SKIP: begin
                if (in_valid && in_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-frame flags captured as bytes arrive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ended_q   <= 1'b0;
            too_long  <= 1'b0;
            too_short <= 1'b0;
        end else if (load_first) begin
            ended_q   <= in_last;
            too_long  <= len_big;
            too_short <= in_last && !len_big;
        end else if (take && in_last) begin
            ended_q   <= 1'b1;
            too_short <= byte_cnt < LAST_IDX;
        end
    end

    // registered decision outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_kind   <= KIND_NONE;
        end else begin
            dec_valid  <= eval;
            dec_accept <= eval && (kind_in != KIND_NONE);
            dec_kind   <= eval ? kind_in : KIND_NONE;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_kind == 3'd0) && !dec_accept);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_accept_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_kind != 3'd0)));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> dec_valid);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_BYTES  = 6,
    parameter int REG_W       = 32,
    parameter int LEN_W       = 16,
    parameter int CTL_W       = 32,
    parameter int MAX_FRAME   = 1518,
    parameter int FILT_EN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [REG_W-1:0]  stn_lo,
    input  logic [REG_W-1:0]  stn_hi,
    input  logic [REG_W-1:0]  mca_lo,
    input  logic [REG_W-1:0]  mca_hi,
    input  logic [REG_W-1:0]  mcm_lo,
    input  logic [REG_W-1:0]  mcm_hi,
    input  logic [CTL_W-1:0]  filt_ctl,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_kind
);

    localparam int ADDR_W = DATA_W * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]  byte_cnt;
    logic [ADDR_W-1:0] dest;
    logic              load_first, take, eval, too_long, too_short;
    match_kind_e       kind_w;

    rxf_addr_shift #(
        .BYTE_W (DATA_W),
        .NBYTES (ADDR_BYTES),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (load_first),
        .take       (take),
        .din        (in_data),
        .byte_cnt   (byte_cnt),
        .addr       (dest)
    );

    rxf_match #(
        .ADDR_W      (ADDR_W),
        .REG_W       (REG_W),
        .CTL_W       (CTL_W),
        .FILT_EN_BIT (FILT_EN_BIT)
    ) u_match (
        .dest      (dest),
        .too_long  (too_long),
        .too_short (too_short),
        .stn_lo    (stn_lo),
        .stn_hi    (stn_hi),
        .mca_lo    (mca_lo),
        .mca_hi    (mca_hi),
        .mcm_lo    (mcm_lo),
        .mcm_hi    (mcm_hi),
        .filt_ctl  (filt_ctl),
        .kind      (kind_w)
    );

    rxf_ctrl_fsm #(
        .NBYTES    (ADDR_BYTES),
        .CNT_W     (CNT_W),
        .LEN_W     (LEN_W),
        .MAX_FRAME (MAX_FRAME)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_last    (in_last),
        .in_len     (in_len),
        .byte_cnt   (byte_cnt),
        .kind_in    (kind_w),
        .load_first (load_first),
        .take       (take),
        .eval       (eval),
        .too_long   (too_long),
        .too_short  (too_short),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_kind   (dec_kind)
    );

    assert_oversize_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eval && too_long |-> kind_w == KIND_NONE);

    assert_short_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eval && too_short |-> kind_w == KIND_NONE);

    assert_bcast_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eval && !too_long && !too_short && (&dest) |-> kind_w == KIND_BCAST);

    assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eval && !too_long && !too_short && !(&dest) && !filt_ctl[FILT_EN_BIT]
        |-> kind_w == KIND_PROMISC);

endmodule

// File: tb/rx_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [15:0] in_len = '0;
    logic [31:0] stn_lo = '0, stn_hi = '0;
    logic [31:0] mca_lo = '0, mca_hi = '0;
    logic [31:0] mcm_lo = '0, mcm_hi = '0;
    logic [31:0] filt_ctl = '0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_kind;

    always #10 clk = ~clk;

    rx_dest_filter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_len(in_len),
        .stn_lo(stn_lo), .stn_hi(stn_hi), .mca_lo(mca_lo), .mca_hi(mca_hi),
        .mcm_lo(mcm_lo), .mcm_hi(mcm_hi), .filt_ctl(filt_ctl),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind)
    );

    typedef struct {
        logic [2:0] kind;
        logic       acc;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t  sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    dec_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop expected decision, compare code, accept flag and edge
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && dec_valid) begin
            dec_seen = dec_seen + 1;
            n_chk = n_chk + 1;
            if (sbq.size() == 0) begin
                n_fail = n_fail + 1;
                $display("FAIL R10 unexpected decision: kind=%0d accept=%0d expected no pulse",
                         dec_kind, dec_accept);
            end else begin
                e = sbq.pop_front();
                if (dec_kind !== e.kind || dec_accept !== e.acc || cyc != e.cyc) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s R9 R11: kind=%0d acc=%0d edge=%0d expected kind=%0d acc=%0d edge=%0d",
                             e.tag, dec_kind, dec_accept, cyc, e.kind, e.acc, e.cyc);
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // driver: sends a frame and queues the expected decision
    task automatic send_frame(input logic [47:0] dest, input int nbytes, input int dlen,
                              input logic [2:0] ek, input string tag);
        int dec_idx;
        dec_idx = (dlen > 1518) ? 0 : ((nbytes < 6) ? nbytes - 1 : 5);
        for (int b = 0; b < nbytes; b++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (b == 0);
            in_last  = (b == nbytes - 1);
            in_len   = 16'(dlen);
            in_data  = (b < 6) ? dest[8*b +: 8] : 8'(b);
            @(posedge clk);
            #1;
            if (b == dec_idx) sbq.push_back('{ek, (ek != 3'd0), cyc + 1, tag});
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL R10 watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seen0;
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0 && dec_accept == 1'b0 && dec_kind == 3'd0,
              "R1 reset outputs", int'(dec_kind), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dec_valid == 1'b0, "R1 after reset", int'(dec_valid), 0);

        // filtering enabled, station 00:11:22:33:44:55 with junk in high bits (R8)
        filt_ctl = 32'h0000_0020;
        stn_lo = 32'h3322_1100; stn_hi = 32'hABCD_5544;
        mca_lo = 32'h005E_0001; mca_hi = 32'hFFFF_0000;
        mcm_lo = 32'h00FF_FFFF; mcm_hi = 32'hFFFF_0000;

        send_frame(48'hFFFF_FFFF_FFFF, 20, 20, 3'd1, "R4 bcast filter on");
        send_frame(48'h5544_3322_1100, 20, 20, 3'd4, "R7 R8 unicast hit");
        send_frame(48'h0044_3322_1100, 20, 20, 3'd0, "R7 unicast miss");
        send_frame(48'h0011_2233_4455, 20, 20, 3'd0, "R8 reversed bytes");
        send_frame(48'h5634_125E_0001, 20, 20, 3'd3, "R6 mcast masked hit");
        send_frame(48'h5634_125E_0003, 20, 20, 3'd0, "R6 mcast miss");
        for (int k = 0; k < 6; k++)
            send_frame({8'(k * 37), 8'(k), 8'(255 - k), 24'h5E_0001}, 8, 8, 3'd3,
                       "R6 mcast masked-off bytes vary");

        // R6: multicast address all ones skips that comparison
        mca_lo = 32'hFFFF_FFFF; mca_hi = 32'h0000_FFFF;
        mcm_lo = 32'h0000_0000; mcm_hi = 32'h0000_0000;
        send_frame(48'h5544_3322_1100, 10, 10, 3'd4, "R6 mcast skipped then unicast");
        send_frame(48'h0000_0000_0000, 10, 10, 3'd0, "R6 skipped, no match");

        // R5: filter disabled, other control bits ignored
        filt_ctl = 32'hFFFF_FFDF;
        send_frame(48'h1234_5678_9ABC, 12, 12, 3'd2, "R5 promiscuous");
        send_frame(48'hFFFF_FFFF_FFFF, 12, 12, 3'd1, "R4 bcast filter off");
        filt_ctl = 32'h0000_0020;

        // R3: short frames
        send_frame(48'hFFFF_FFFF_FFFF, 5, 5, 3'd0, "R3 five bytes");
        send_frame(48'hFFFF_FFFF_FFFF, 1, 1, 3'd0, "R3 single byte");
        send_frame(48'h5544_3322_1100, 6, 6, 3'd4, "R9 exactly six bytes");

        // R2: oversize boundary
        send_frame(48'hFFFF_FFFF_FFFF, 9, 1519, 3'd0, "R2 oversize");
        send_frame(48'hFFFF_FFFF_FFFF, 3, 1519, 3'd0, "R2 oversize short");
        send_frame(48'hFFFF_FFFF_FFFF, 9, 1518, 3'd1, "R2 at limit");

        // R10: long frame, one decision only
        seen0 = dec_seen;
        send_frame(48'h5544_3322_1100, 60, 60, 3'd4, "R10 long frame");
        repeat (4) @(negedge clk);
        check(dec_seen == seen0 + 1, "R10 one decision per frame", dec_seen - seen0, 1);

        // R10: stray bytes while idle
        seen0 = dec_seen;
        @(negedge clk);
        in_valid = 1'b1; in_first = 1'b0; in_last = 1'b0; in_data = 8'hFF;
        repeat (4) @(negedge clk);
        in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (5) @(negedge clk);
        check(dec_seen == seen0, "R10 stray bytes ignored", dec_seen - seen0, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 7, 7, 3'd1, "R10 frame after stray bytes");

        repeat (5) @(negedge clk);
        check(sbq.size() == 0, "R10 all expected decisions seen", sbq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule